// File: doc/BRIEF.md
# CAN Transmit Pin Driver Controller

This block is the output stage between a CAN protocol engine and the two transmit pins of a bus transceiver. It does not drive the pins itself. For each pin it produces two enables, one for the high-side (pull-up) transistor and one for the low-side (pull-down) transistor. An 8-bit configuration register sets these enables. The register holds, for each pin, a polarity bit and two transistor-enable bits, plus a two-bit mode field. Software can read and write the register only while the controller's reset-request input is high.

There are four modes:
- **Normal:** the transmit bit goes to both pins.
- **Clock:** pin 1 carries the transmit clock instead.
- **Test:** pin 1 follows the receive comparator output, so the transmit-to-receive loop delay can be measured.
- **Bi-phase:** this mode is DC-free for transformer coupling. Recessive bits float both pins. Dominant bits go alternately to pin 0 and pin 1, starting with pin 0.

Sleep and reset-request override every mode. Sleep drives the recessive level on both pins. Reset-request floats both pins.

Top module: `can_tx_pin_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, the register is 8'h00. While `rst_req` is 1, `cfg_rdata` shows the register, laid out from bit 7 down to bit 0 as {TP1, TN1, POL1, TP0, TN0, POL0, MODE[1:0]}. While `rst_req` is 0, `cfg_rdata` is 8'h00.
- R2: A write (`cfg_wr`=1) at a clock edge loads `cfg_wdata` only if `rst_req` is 1 at that edge. Otherwise the register is unchanged.
- R3: While `rst_req` is 1, all four driver enables are 0. This takes priority over sleep and every mode.
- R4: While `sleep` is 1 and `rst_req` is 0, each pin is driven with a data value of 1, through that pin's polarity and driver-enable bits (R5).
- R5: For each pin, v = data XOR POL. `up` = v AND TP, and `dn` = (NOT v) AND TN.
- R6: In mode 2'b10 (normal), both pins use `tx_bit` as their data.
- R7: In mode 2'b11 (clock), pin 0 uses `tx_bit` and pin 1 uses `tx_clk`.
- R8: In mode 2'b01 (test), pin 0 uses `tx_bit` and pin 1 uses `cmp_out`.
- R9: In mode 2'b00 (bi-phase), `tx_bit`=1 (recessive) turns off all enables. `tx_bit`=0 (dominant) drives data 0 on the selected pin only, and the other pin floats.
- R10: The bi-phase selector chooses pin 0 when it is 0 and pin 1 when it is 1.
  - It clears to 0 at any edge where `rst_req` is 1 or the mode is not 2'b00.
  - Otherwise it toggles at an edge where `bit_strobe`=1, `tx_bit`=0 and `sleep`=0.
  - As a result, the first dominant bit after entering the mode goes to pin 0.
- R11: No pin ever has `up` and `dn` both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (zero unless rst_req) |
| rst_req | input | 1 | Controller reset-request state |
| sleep | input | 1 | Controller sleep state |
| tx_bit | input | 1 | Serial transmit bit, 0 = dominant |
| tx_clk | input | 1 | Transmit clock for clock mode |
| cmp_out | input | 1 | Receive comparator output for test mode |
| bit_strobe | input | 1 | High on the last cycle of each bit period |
| pin0_up | output | 1 | Pin 0 high-side enable |
| pin0_dn | output | 1 | Pin 0 low-side enable |
| pin1_up | output | 1 | Pin 1 high-side enable |
| pin1_dn | output | 1 | Pin 1 low-side enable |

## Verification
The bi-phase selector is the only internal state apart from the register. If it goes wrong, the next dominant bit after a strobe appears on the wrong pin. That error is visible on the enables in the same cycle and is caught at once. A selector that is not cleared on entering the mode shows up only at the first dominant bit after `rst_req` falls. A register that accepts a write while `rst_req` is 0 shows up only when `rst_req` rises again and the register is read back, or at once as changed pin enables. The bench therefore mixes random writes with rare reset-request windows.

// File: rtl/can_tx_pin_pkg.sv
`timescale 1ns/1ps
// Shared types for the CAN transmit pin driver controller.
// The packed field order is the register layout that software sees.
package can_tx_pin_pkg;

    localparam int CFG_W  = 8;
    localparam int MODE_W = 2;
    localparam int NPINS  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_BIPHASE = 2'b00,
        MODE_TEST    = 2'b01,
        MODE_NORMAL  = 2'b10,
        MODE_CLOCK   = 2'b11
    } tx_mode_e;

    typedef struct packed {
        logic     tp1;
        logic     tn1;
        logic     pol1;
        logic     tp0;
        logic     tn0;
        logic     pol0;
        tx_mode_e mode;
    } tx_cfg_t;

endpackage

// File: rtl/can_tx_cfg_reg.sv
`timescale 1ns/1ps
// Output configuration register.
// Loads on a write only while the controller is in reset-request.
// The read data is zero outside reset-request.
// Assumes: synchronous active-low reset, single clock domain.
module can_tx_cfg_reg
    import can_tx_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output tx_cfg_t          cfg,
    output logic [CFG_W-1:0] rdata
);

    // Purpose: hold the configuration; accept writes only in reset-request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= tx_cfg_t'('0);
        end else if (rst_req && wr) begin
            cfg <= tx_cfg_t'(wdata);
        end
    end

    // Purpose: show the register only while reset-request is high.
    always_comb begin
        rdata = rst_req ? CFG_W'(cfg) : '0;
    end

    // R2: outside reset-request the register holds its value
    a_r2_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |=> $stable(cfg));

endmodule

// File: rtl/can_tx_biphase_sel.sv
`timescale 1ns/1ps
// Bi-phase pin selector: 0 = next dominant bit goes to pin 0, 1 = pin 1.
// Clear has priority over advance.
// Assumes: the caller raises advance once per dominant bit, at its strobe.
module can_tx_biphase_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic sel
);

    // Purpose: alternate the target pin per dominant bit; restart at pin 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= 1'b0;
        end else if (clear) begin
            sel <= 1'b0;
        end else if (advance) begin
            sel <= ~sel;
        end
    end

    // R10: each counted dominant bit moves to the other pin
    a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear) |=> (sel != $past(sel)));

    // R10: after a clear the next dominant bit goes to pin 0
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !sel);

endmodule

// File: rtl/can_tx_pin_drv.sv
`timescale 1ns/1ps
// Per-pin driver enable logic.
// The data value is XORed with the polarity bit. Each transistor turns on
// only if its enable bit is set, and only if the pin is active.
// Assumes: the caller sets active low to float the pin.
module can_tx_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic data,
    input  logic pol,
    input  logic tp,
    input  logic tn,
    output logic up,
    output logic dn
);

    logic level;

    // Purpose: turn the polarity-adjusted level into transistor enables.
    always_comb begin
        level = data ^ pol;
        up    = active &&  level && tp;
        dn    = active && !level && tn;
    end

    // R11: never both transistors of one pin
    a_r11_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

endmodule

// File: rtl/can_tx_pin_ctrl.sv
`timescale 1ns/1ps
// CAN transmit pin driver controller (top).
// Selects per-pin data and activity from the mode, then applies the
// sleep and reset-request overrides. Reset-request wins over sleep.
// Assumes: tx_bit, tx_clk, cmp_out and bit_strobe are synchronous to clk.
module can_tx_pin_ctrl
    import can_tx_pin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             rst_req,
    input  logic             sleep,
    input  logic             tx_bit,
    input  logic             tx_clk,
    input  logic             cmp_out,
    input  logic             bit_strobe,
    output logic             pin0_up,
    output logic             pin0_dn,
    output logic             pin1_up,
    output logic             pin1_dn
);

    tx_cfg_t           cfg;
    logic              bp_sel;
    logic              bp_clear;
    logic              bp_adv;
    logic [NPINS-1:0]  pin_data;
    logic [NPINS-1:0]  pin_act;
    logic [NPINS-1:0]  pin_pol;
    logic [NPINS-1:0]  pin_tp;
    logic [NPINS-1:0]  pin_tn;
    logic [NPINS-1:0]  pin_up;
    logic [NPINS-1:0]  pin_dn;

    can_tx_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_req (rst_req),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .rdata   (cfg_rdata)
    );

    // Purpose: restart bi-phase at pin 0 and count dominant bits.
    always_comb begin
        bp_clear = rst_req || (cfg.mode != MODE_BIPHASE);
        bp_adv   = bit_strobe && !tx_bit && !sleep;
    end

    can_tx_biphase_sel u_bp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (bp_clear),
        .advance (bp_adv),
        .sel     (bp_sel)
    );

    // Purpose: pick per-pin data and activity from mode and overrides.
    always_comb begin
        pin_data = {NPINS{tx_bit}};
        pin_act  = '1;
        if (rst_req) begin
            pin_act = '0;
        end else if (sleep) begin
            pin_data = '1;
        end else begin
            unique case (cfg.mode)
                MODE_NORMAL: ;
                MODE_CLOCK:  pin_data[1] = tx_clk;
                MODE_TEST:   pin_data[1] = cmp_out;
                MODE_BIPHASE: begin
                    pin_data   = '0;
                    pin_act[0] = !tx_bit && !bp_sel;
                    pin_act[1] = !tx_bit &&  bp_sel;
                end
                default: ;
            endcase
        end
    end

    // Purpose: gather the per-pin configuration bits.
    always_comb begin
        pin_pol = {cfg.pol1, cfg.pol0};
        pin_tp  = {cfg.tp1,  cfg.tp0};
        pin_tn  = {cfg.tn1,  cfg.tn0};
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        can_tx_pin_drv u_drv (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (pin_act[p]),
            .data   (pin_data[p]),
            .pol    (pin_pol[p]),
            .tp     (pin_tp[p]),
            .tn     (pin_tn[p]),
            .up     (pin_up[p]),
            .dn     (pin_dn[p])
        );
    end

    // Purpose: map the pin vectors onto the named ports.
    always_comb begin
        pin0_up = pin_up[0];
        pin0_dn = pin_dn[0];
        pin1_up = pin_up[1];
        pin1_dn = pin_dn[1];
    end

    // R3: reset-request floats every driver
    a_r3_float_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !(pin0_up || pin0_dn || pin1_up || pin1_dn));

    // R9: recessive bits in bi-phase mode leave both pins floating
    a_r9_recessive_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !sleep && cfg.mode == MODE_BIPHASE && tx_bit)
            |-> !(pin0_up || pin0_dn || pin1_up || pin1_dn));

    // R9: in bi-phase mode at most one pin is driven at a time
    a_r9_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !sleep && cfg.mode == MODE_BIPHASE)
            |-> !((pin0_up || pin0_dn) && (pin1_up || pin1_dn)));

endmodule

// File: tb/test_can_tx_pin_ctrl.sv
`timescale 1ns/1ps
module test_can_tx_pin_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       rst_req, sleep, tx_bit, tx_clk, cmp_out, bit_strobe;
    logic       pin0_up, pin0_dn, pin1_up, pin1_dn;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    logic [7:0] m_cfg;
    logic       m_sel;

    always #2.5 clk = ~clk;

    can_tx_pin_ctrl i_can_tx_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rst_req(rst_req), .sleep(sleep),
        .tx_bit(tx_bit), .tx_clk(tx_clk), .cmp_out(cmp_out),
        .bit_strobe(bit_strobe), .pin0_up(pin0_up), .pin0_dn(pin0_dn),
        .pin1_up(pin1_up), .pin1_dn(pin1_dn)
    );

    // R5 rule: returns {up, dn}
    function automatic logic [1:0] drv(logic d, logic pol, logic tp, logic tn);
        logic v;
        v = d ^ pol;
        return {v & tp, ~v & tn};
    endfunction

    // expected {pin1_up, pin1_dn, pin0_up, pin0_dn}
    function automatic logic [3:0] exp_pins(logic [7:0] c, logic rr, logic sl,
                                            logic tx, logic tc, logic cm, logic sel);
        logic d0, d1, e0, e1;
        if (rr) return 4'b0000;
        d0 = tx; d1 = tx; e0 = 1'b1; e1 = 1'b1;
        if (sl) begin
            d0 = 1'b1; d1 = 1'b1;
        end else begin
            case (c[1:0])
                2'b11: d1 = tc;
                2'b01: d1 = cm;
                2'b00: begin
                    d0 = 1'b0; d1 = 1'b0;
                    e0 = ~tx & ~sel; e1 = ~tx & sel;
                end
                default: ;
            endcase
        end
        return {drv(d1, c[5], c[7], c[6]) & {2{e1}},
                drv(d0, c[2], c[4], c[3]) & {2{e0}}};
    endfunction

    function automatic string tag(logic [7:0] c, logic rr, logic sl);
        if (rr) return "R3";
        if (sl) return "R4 R5";
        case (c[1:0])
            2'b10:   return "R5 R6";
            2'b11:   return "R7";
            2'b01:   return "R8";
            default: return "R9 R10";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic wr, logic [7:0] wd, logic rr, logic sl, logic tx,
                        logic tc, logic cm, logic st);
        logic [7:0] n_cfg;
        logic       n_sel;
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = wd; rst_req = rr; sleep = sl;
        tx_bit = tx; tx_clk = tc; cmp_out = cm; bit_strobe = st;
        #1;
        chk(tag(m_cfg, rr, sl), {pin1_up, pin1_dn, pin0_up, pin0_dn},
            exp_pins(m_cfg, rr, sl, tx, tc, cm, m_sel));
        chk("R11", (pin0_up & pin0_dn) | (pin1_up & pin1_dn), 0);
        chk("R1", cfg_rdata, rr ? m_cfg : 8'h00);
        n_cfg = (rr && wr) ? wd : m_cfg;   // R2
        if (rr || m_cfg[1:0] != 2'b00) n_sel = 1'b0;
        else if (st && !tx && !sl)      n_sel = ~m_sel;
        else                            n_sel = m_sel;
        @(posedge clk);
        m_cfg = n_cfg;
        m_sel = n_sel;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        rst_n = 1'b0; cfg_wr = 0; cfg_wdata = 0; rst_req = 1; sleep = 0;
        tx_bit = 1; tx_clk = 0; cmp_out = 0; bit_strobe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", cfg_rdata, 8'h00);  // R1 reset value
        chk("R3", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 0);
        rst_n = 1'b1;
        m_cfg = 8'h00; m_sel = 1'b0;

        // R2 directed: write in reset-request, then ignored write outside it
        step(1, 8'hDA, 1, 0, 1, 0, 0, 0);
        step(1, 8'h55, 0, 0, 1, 0, 0, 0);
        step(0, 8'h00, 1, 0, 1, 0, 0, 0);
        chk("R2", cfg_rdata, 8'hDA);

        // R9/R10 directed: bi-phase push-pull, polarity 0 (0xD8)
        step(1, 8'hD8, 1, 0, 1, 0, 0, 0);
        @(negedge clk); rst_req = 0; tx_bit = 0; bit_strobe = 1; sleep = 0; cfg_wr = 0;
        #1; chk("R10", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b0001);
        @(posedge clk); m_sel = 1'b1;
        @(negedge clk); #1;
        chk("R10", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b0100);
        @(posedge clk); m_sel = 1'b0;
        @(negedge clk); tx_bit = 1; #1;
        chk("R9", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b0000);
        @(posedge clk);
        @(negedge clk); tx_bit = 0; bit_strobe = 0; #1;
        chk("R10", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b0001);
        @(posedge clk);
        // R4 directed: sleep gives recessive level (data 1 -> pull-up)
        @(negedge clk); sleep = 1; #1;
        chk("R4", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b1010);
        @(posedge clk);
        // R3 directed: reset-request wins over sleep
        @(negedge clk); rst_req = 1; #1;
        chk("R3", {pin1_up, pin1_dn, pin0_up, pin0_dn}, 4'b0000);
        @(posedge clk);

        // random phases
        for (int ph = 0; ph < 40; ph++) begin
            step(1, 8'($urandom), 1, 0, 1, 0, 0, 0);
            for (int i = 0; i < 80; i++) begin
                step(($urandom % 4) == 0, 8'($urandom),
                     ($urandom % 64) == 0, ($urandom % 16) == 0,
                     1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 3) == 0);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule